// File: doc/BRIEF.md
# ADC Interrupt Status Flag Register

This block holds the sticky event flags of an analog-to-digital converter controller and turns them into one interrupt line. The converter sequencer, the window comparators, the calibration engine and the regulator monitor each deliver single-cycle pulses. The block latches each pulse into its own flag bit, and the bit stays set until software acknowledges it. Software reads the flags and the interrupt enables over a small register bus. It clears a flag by writing a 1 to that flag's bit.

Two flags have extra behaviour. The conversion-complete flag also clears when the data register is read, which the surrounding logic signals with a one-cycle pulse. The overrun flag is derived inside the block: it sets when a new conversion result arrives while the previous result is still pending. The interrupt output is a registered OR of the flags masked by the enable register.

Top module: `adc_irq_flags`

## Requirements
- R1: After synchronous reset every flag, every enable bit and the interrupt output are 0.
- R2: Each event pulse sets its own flag, and the flag stays set until it is cleared. The bit positions are: ready 0, sampling end 1, conversion complete 2, sequence end 3, overrun 4, window watchdogs 7, 8 and 9, calibration done 11, regulator ready 12. The sequence end flag sets only from its own pulse and never from a conversion pulse.
- R3: A bus write to address 0 (status) clears every flag whose write-data bit is 1. Bits written as 0 leave their flags unchanged.
- R4: When an event pulse and a write-1 clear reach the same flag in the same cycle, the flag is set after that cycle.
- R5: A data-read pulse clears the conversion-complete flag if no conversion pulse comes in the same cycle.
- R6: A conversion pulse that arrives while the conversion-complete flag is set, with no data-read pulse in that cycle, sets the overrun flag. This happens even if the same cycle carries a write-1 clear of the conversion flag.
- R7: A conversion pulse together with a data-read pulse leaves the conversion-complete flag set and does not set overrun.
- R8: Address 1 holds the interrupt enable register, and only the ten flag bit positions of it can be written. Bits 5, 6, 10 and 13 to 15 read 0 at addresses 0 and 1. Addresses 2 and 3 read 0. Writes to addresses 2 and 3 change nothing.
- R9: The interrupt output equals the OR over all bits of (flags AND enables) as they were one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_ready | input | 1 | Converter is enabled and can accept requests |
| evt_samp_end | input | 1 | Sampling phase of a conversion has ended |
| evt_conv_done | input | 1 | New channel result is available |
| evt_seq_done | input | 1 | Last channel of the sequence has been converted |
| evt_wdg | input | 3 | Window watchdog events, one bit per watchdog |
| evt_cal_done | input | 1 | Calibration has completed |
| evt_vreg_ok | input | 1 | Internal regulator is stable |
| data_rd | input | 1 | Data register is being read in this cycle |
| bus_addr | input | 2 | Register address: 0 status, 1 enable |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest cases to reach are the same-cycle collisions. One is a conversion pulse together with a data read, a write-1 clear, or both, while the conversion flag is already pending. Another is an event pulse that lands in the same cycle as its own clear. Directed steps first set the conversion flag and then apply each collision in a single cycle. A long random phase then drives sparse event pulses, frequent data reads and random write-1 masks together, so these overlaps keep recurring. On every clock the outputs are compared against a behavioural model.

// File: rtl/adc_irq_pkg.sv
package adc_irq_pkg;

    localparam int FLAG_W  = 16;
    localparam int NUM_WDG = 3;

    localparam int B_RDY  = 0;
    localparam int B_SMP  = 1;
    localparam int B_EOC  = 2;
    localparam int B_EOS  = 3;
    localparam int B_OVR  = 4;
    localparam int B_WD0  = 7;
    localparam int B_CAL  = 11;
    localparam int B_VREG = 12;

    typedef enum logic [1:0] {
        A_STATUS = 2'd0,
        A_ENABLE = 2'd1
    } reg_addr_e;

    typedef struct packed {
        logic               ready;
        logic               samp_end;
        logic               conv_done;
        logic               seq_done;
        logic [NUM_WDG-1:0] wdg;
        logic               cal_done;
        logic               vreg_ok;
    } hw_evt_t;

    function automatic logic [FLAG_W-1:0] valid_mask();
        logic [FLAG_W-1:0] m;
        m = '0;
        m[B_RDY]  = 1'b1;
        m[B_SMP]  = 1'b1;
        m[B_EOC]  = 1'b1;
        m[B_EOS]  = 1'b1;
        m[B_OVR]  = 1'b1;
        for (int i = 0; i < NUM_WDG; i++) m[B_WD0 + i] = 1'b1;
        m[B_CAL]  = 1'b1;
        m[B_VREG] = 1'b1;
        return m;
    endfunction

    function automatic logic [FLAG_W-1:0] evt_to_vec(hw_evt_t e);
        logic [FLAG_W-1:0] v;
        v = '0;
        v[B_RDY]  = e.ready;
        v[B_SMP]  = e.samp_end;
        v[B_EOC]  = e.conv_done;
        v[B_EOS]  = e.seq_done;
        for (int i = 0; i < NUM_WDG; i++) v[B_WD0 + i] = e.wdg[i];
        v[B_CAL]  = e.cal_done;
        v[B_VREG] = e.vreg_ok;
        return v;
    endfunction

endpackage

// File: rtl/adc_irq_regbus.sv
module adc_irq_regbus
    import adc_irq_pkg::*;
#(
    parameter int DATA_W = FLAG_W,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [FLAG_W-1:0] flags,
    output logic [FLAG_W-1:0] clr_vec,
    output logic [FLAG_W-1:0] en_q,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam logic [FLAG_W-1:0] VALID = valid_mask();

    logic              sel_status;
    logic              sel_enable;
    logic [FLAG_W-1:0] wmask;
    logic [FLAG_W-1:0] rsel;

    always_comb begin
        sel_status = (bus_addr == ADDR_W'(A_STATUS));
        sel_enable = (bus_addr == ADDR_W'(A_ENABLE));
        wmask      = FLAG_W'(bus_wdata) & VALID;
        clr_vec    = (bus_wr && sel_status) ? wmask : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (bus_wr && sel_enable) begin
            en_q <= wmask;
        end
    end

    always_comb begin
        rsel = '0;
        if (sel_status) rsel = flags & VALID;
        else if (sel_enable) rsel = en_q;
        bus_rdata = DATA_W'(rsel);
    end

    // R8: enable register only changes on a write to its address
    p_en_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && sel_enable) |=> $stable(en_q));

    // R8: unmapped addresses never return data
    always_comb begin
        if (!rst && !sel_status && !sel_enable) begin
            p_unmapped_zero_r8: assert (bus_rdata == '0);
        end
    end

endmodule

// File: rtl/adc_irq_flagbank.sv
module adc_irq_flagbank
    import adc_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  hw_evt_t           evt,
    input  logic              data_rd,
    input  logic [FLAG_W-1:0] clr_vec,
    output logic [FLAG_W-1:0] flag_q
);
    localparam logic [FLAG_W-1:0] VALID = valid_mask();

    logic [FLAG_W-1:0] set_vec;
    logic [FLAG_W-1:0] clr_eff;
    logic              ovr_evt;

    always_comb begin
        ovr_evt          = evt.conv_done & flag_q[B_EOC] & ~data_rd;
        set_vec          = evt_to_vec(evt);
        set_vec[B_OVR]   = ovr_evt;
        clr_eff          = clr_vec;
        clr_eff[B_EOC]   = clr_vec[B_EOC] | data_rd;
    end

    for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
        if (VALID[i]) begin : g_live
            always_ff @(posedge clk) begin
                if (rst) flag_q[i] <= 1'b0;
                else     flag_q[i] <= set_vec[i] | (flag_q[i] & ~clr_eff[i]);
            end

            // R4: an event is never lost to a simultaneous clear
            p_set_wins_r4: assert property (@(posedge clk) disable iff (rst)
                set_vec[i] |=> flag_q[i]);

            // R3: a clear without a competing event drops the flag
            p_w1c_r3: assert property (@(posedge clk) disable iff (rst)
                (clr_eff[i] && !set_vec[i]) |=> !flag_q[i]);
        end else begin : g_tie
            assign flag_q[i] = 1'b0;
        end
    end

    // R5: data read acknowledges the conversion flag
    p_rd_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (data_rd && !evt.conv_done) |=> !flag_q[B_EOC]);

    // R6: new result on top of a pending one raises overrun
    p_ovr_on_pending_r6: assert property (@(posedge clk) disable iff (rst)
        (evt.conv_done && flag_q[B_EOC] && !data_rd) |=> flag_q[B_OVR]);

    // R7: overrun only rises from a conversion without a data read
    p_no_ovr_on_rd_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q[B_OVR]) |-> $past(evt.conv_done && !data_rd));

endmodule

// File: rtl/adc_irq_line.sv
module adc_irq_line
    import adc_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [FLAG_W-1:0] flags,
    input  logic [FLAG_W-1:0] en,
    output logic              irq_q
);
    logic pend;

    always_comb pend = |(flags & en);

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= pend;
    end

    // R9: the line only rises after an enabled flag was pending
    p_irq_cause_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_q) |-> $past(pend));

    // R9: the line drops one cycle after nothing enabled is pending
    p_irq_drop_r9: assert property (@(posedge clk) disable iff (rst)
        !pend |=> !irq_q);

endmodule

// File: rtl/adc_irq_flags.sv
module adc_irq_flags
    import adc_irq_pkg::*;
#(
    parameter int DATA_W = FLAG_W,
    parameter int ADDR_W = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               evt_ready,
    input  logic               evt_samp_end,
    input  logic               evt_conv_done,
    input  logic               evt_seq_done,
    input  logic [NUM_WDG-1:0] evt_wdg,
    input  logic               evt_cal_done,
    input  logic               evt_vreg_ok,
    input  logic               data_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq
);
    hw_evt_t           evt;
    logic [FLAG_W-1:0] flags;
    logic [FLAG_W-1:0] clr_vec;
    logic [FLAG_W-1:0] en_q;

    always_comb begin
        evt.ready     = evt_ready;
        evt.samp_end  = evt_samp_end;
        evt.conv_done = evt_conv_done;
        evt.seq_done  = evt_seq_done;
        evt.wdg       = evt_wdg;
        evt.cal_done  = evt_cal_done;
        evt.vreg_ok   = evt_vreg_ok;
    end

    adc_irq_regbus #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regbus (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .flags     (flags),
        .clr_vec   (clr_vec),
        .en_q      (en_q),
        .bus_rdata (bus_rdata)
    );

    adc_irq_flagbank u_flags (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .data_rd (data_rd),
        .clr_vec (clr_vec),
        .flag_q  (flags)
    );

    adc_irq_line u_line (
        .clk   (clk),
        .rst   (rst),
        .flags (flags),
        .en    (en_q),
        .irq_q (irq)
    );

    // R1: one cycle out of reset, nothing is pending
    p_reset_clear_r1: assert property (@(posedge clk)
        $fell(rst) |-> (flags == '0 && en_q == '0 && !irq));

endmodule

// File: tb/adc_irq_flags_bench.sv
module adc_irq_flags_bench;

    localparam logic [15:0] VALID = 16'h1B9F;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        evt_ready = 0, evt_samp_end = 0, evt_conv_done = 0, evt_seq_done = 0;
    logic [2:0]  evt_wdg = '0;
    logic        evt_cal_done = 0, evt_vreg_ok = 0, data_rd = 0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;

    always #2.5 clk = ~clk;

    adc_irq_flags u_adc_irq_flags (
        .clk(clk), .rst(rst),
        .evt_ready(evt_ready), .evt_samp_end(evt_samp_end),
        .evt_conv_done(evt_conv_done), .evt_seq_done(evt_seq_done),
        .evt_wdg(evt_wdg), .evt_cal_done(evt_cal_done), .evt_vreg_ok(evt_vreg_ok),
        .data_rd(data_rd), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] m_flags = '0;
    logic [15:0] m_en = '0;
    logic        m_irq = 0;

    task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare(string tag);
        logic [15:0] exp_rd;
        exp_rd = (bus_addr == 2'd0) ? m_flags : (bus_addr == 2'd1) ? m_en : 16'h0;
        check(tag, "rdata", bus_rdata, exp_rd);
        check(tag, "irq", {15'b0, irq}, {15'b0, m_irq});
    endtask

    // ev uses the flag bit layout; bit 4 is not an input
    task automatic step(string tag, logic [15:0] ev, logic drd,
                        logic [1:0] a, logic w, logic [15:0] wd);
        logic [15:0] clr, sets, nf, ne;
        logic        ni;
        evt_ready = ev[0]; evt_samp_end = ev[1]; evt_conv_done = ev[2];
        evt_seq_done = ev[3]; evt_wdg = ev[9:7]; evt_cal_done = ev[11];
        evt_vreg_ok = ev[12]; data_rd = drd;
        bus_addr = a; bus_wr = w; bus_wdata = wd;
        clr  = (w && a == 2'd0) ? (wd & VALID) : 16'h0;
        ne   = (w && a == 2'd1) ? (wd & VALID) : m_en;
        ni   = |(m_flags & m_en);
        nf   = m_flags & ~clr;
        if (drd) nf[2] = 1'b0;
        sets = ev & VALID & ~16'h0010;
        if (ev[2] && m_flags[2] && !drd) sets[4] = 1'b1;
        nf   = nf | sets;
        @(negedge clk);
        m_flags = nf; m_en = ne; m_irq = ni;
        compare(tag);
    endtask

    task automatic idle(string tag, logic [1:0] a, int n);
        for (int k = 0; k < n; k++) step(tag, 16'h0, 1'b0, a, 1'b0, 16'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1", "status after reset", bus_rdata, 16'h0);
        check("R1", "irq after reset", {15'b0, irq}, 16'h0);
        step("R1", 16'h0, 0, 2'd1, 0, 16'h0);
        check("R1", "enable after reset", bus_rdata, 16'h0);

        // R2: each event alone, flag sticky
        for (int b = 0; b < 16; b++) begin
            if (VALID[b] && b != 4) begin
                step("R2", 16'h1 << b, 0, 2'd0, 0, 16'h0);
                idle("R2", 2'd0, 2);
                check("R2", "sticky bit", bus_rdata, 16'h1 << b);
                step("R3", 16'h0, 0, 2'd0, 1, 16'hFFFF);
            end
        end
        // R2: sequence end not raised by conversion pulses
        step("R2", 16'h0004, 0, 2'd0, 0, 16'h0);
        step("R2", 16'h0000, 1, 2'd0, 0, 16'h0);
        check("R2", "no sequence flag from conversion", bus_rdata & 16'h0008, 16'h0);

        // R3: write 0 no effect, write 1 clears selected bits
        step("R3", 16'h1B8F, 0, 2'd0, 0, 16'h0);
        step("R3", 16'h0, 0, 2'd0, 1, 16'h0000);
        check("R3", "write zero keeps", bus_rdata, 16'h1B8F);
        step("R3", 16'h0, 0, 2'd0, 1, 16'h0881);
        check("R3", "partial clear", bus_rdata, 16'h130E);
        step("R3", 16'h0, 0, 2'd0, 1, 16'hFFFF);

        // R4: set and clear in the same cycle
        step("R4", 16'h0008, 0, 2'd0, 0, 16'h0);
        step("R4", 16'h0008, 0, 2'd0, 1, 16'h0008);
        check("R4", "set wins", bus_rdata, 16'h0008);
        step("R4", 16'h0, 0, 2'd0, 1, 16'hFFFF);

        // R5: data read clears conversion flag
        step("R5", 16'h0004, 0, 2'd0, 0, 16'h0);
        step("R5", 16'h0, 1, 2'd0, 0, 16'h0);
        check("R5", "read clears", bus_rdata, 16'h0);

        // R6: overrun
        step("R6", 16'h0004, 0, 2'd0, 0, 16'h0);
        step("R6", 16'h0004, 0, 2'd0, 0, 16'h0);
        check("R6", "overrun set", bus_rdata, 16'h0014);
        step("R6", 16'h0, 0, 2'd0, 1, 16'h0010);
        step("R6", 16'h0004, 0, 2'd0, 1, 16'h0004);
        check("R6", "overrun with clear", bus_rdata, 16'h0014);
        step("R6", 16'h0, 0, 2'd0, 1, 16'hFFFF);

        // R7: read and new result together
        step("R7", 16'h0004, 0, 2'd0, 0, 16'h0);
        step("R7", 16'h0004, 1, 2'd0, 0, 16'h0);
        check("R7", "kept, no overrun", bus_rdata, 16'h0004);
        step("R7", 16'h0, 0, 2'd0, 1, 16'hFFFF);

        // R8: enable mask, unmapped addresses
        step("R8", 16'h0, 0, 2'd1, 1, 16'hFFFF);
        check("R8", "enable masked", bus_rdata, VALID);
        step("R8", 16'h1B9F, 0, 2'd2, 1, 16'h0000);
        check("R8", "addr2 reads zero", bus_rdata, 16'h0);
        step("R8", 16'h0, 0, 2'd3, 1, 16'hFFFF);
        check("R8", "addr3 reads zero", bus_rdata, 16'h0);
        step("R8", 16'h0, 0, 2'd1, 0, 16'h0);
        check("R8", "enable unchanged", bus_rdata, VALID);
        step("R8", 16'h0, 0, 2'd0, 0, 16'h0);
        check("R8", "status unchanged", bus_rdata, 16'h1B8F);
        step("R8", 16'h0, 0, 2'd0, 1, 16'hFFFF);

        // R9: irq one cycle behind
        step("R9", 16'h0, 0, 2'd1, 1, 16'h0008);
        idle("R9", 2'd0, 2);
        step("R9", 16'h0008, 0, 2'd0, 0, 16'h0);
        check("R9", "irq not yet", {15'b0, irq}, 16'h0);
        step("R9", 16'h0, 0, 2'd0, 0, 16'h0);
        check("R9", "irq raised", {15'b0, irq}, 16'h1);
        step("R9", 16'h0001, 0, 2'd0, 1, 16'h0008);
        step("R9", 16'h0, 0, 2'd0, 0, 16'h0);
        check("R9", "irq cleared, disabled flag ignored", {15'b0, irq}, 16'h0);

        // mixed random traffic
        for (int k = 0; k < 4000; k++) begin
            logic [15:0] ev, wd;
            logic [1:0]  a;
            ev = 16'($urandom) & 16'($urandom) & 16'($urandom);
            ev[2] = ($urandom % 3 == 0);
            wd = 16'($urandom);
            a  = 2'($urandom);
            step("R6", ev, ($urandom % 3 == 0), a, ($urandom % 4 == 0), wd);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule